// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers interrupt-pending flags from 22 sources and decides which one, if any, a simple CPU should service next. Each flag is set by a one-cycle pulse from its peripheral or by a software write. A per-source enable and one global enable gate the flags. A per-source priority bit places each source in a high or a low group. Within a group the lowest-numbered source wins.

A request is raised only when the CPU reports that an instruction has completed. The request then holds, together with its source index and vector address, until the CPU acknowledges it. Acknowledging the request records the serviced level in an in-service tracker. A return-from-interrupt strobe removes the most recent level from it. A low-level service routine can be preempted only by the high group. Nothing can preempt a high-level routine.

Each source chooses whether its flag clears in hardware on acknowledge or stays set until software writes it to 0. A flag left set across a return requests service again at the next instruction boundary.

Top module: `irq_arbiter`

## Requirements
- R1: There are 22 sources (index 0..21). A pulse on `src_set[k]` sets flag k even while source k is disabled. The disabled flag raises no request, but once its enable is written to 1 the held flag raises a request at the next instruction boundary.
- R2: A source can request only while its enable bit (`wr_sel`=1) is 1 and the global enable is 1. The global enable is written through `wr_sel`=4 and taken from `wr_data[0]`. With the global enable at 0, no request is raised.
- R3: `irq_req` rises only in the cycle after `insn_done` was high. Once raised, `irq_req`, `irq_idx` and `irq_vec` hold until `vec_ack`, and `irq_req` is low in the cycle after the acknowledge.
- R4: Sources whose priority bit (`wr_sel`=2) is 1 form the high group and beat every low-group source. Within a group, the lowest index wins.
- R5: `irq_vec` equals 0x0003 + 8 × `irq_idx`.
- R6: If the auto-clear bit of a source (`wr_sel`=3) is 1, acknowledging that source clears its flag. Otherwise the flag stays set until software writes it to 0 through `wr_sel`=0.
- R7: If an enabled flag is still set when `reti` pulses, the request returns on the first `insn_done` after the `reti` cycle, and not before it.
- R8: Writing a 1 into a flag through `wr_sel`=0 raises a request exactly as a hardware pulse does.
- R9: While a low-level source is in service, only high-group sources may request. While a high-level source is in service, nothing may request. Each `reti` ends the most recently entered level.
- R10: A hardware set pulse and a software write of 0 to the same flag in the same cycle leave the flag set.
- R11: After reset, all flags, enables, priority bits, auto-clear bits and the global enable are 0, nothing is in service, `irq_req` is 0 and `irq_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 22 | One-cycle set pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Selects the register to write: 0 flags, 1 enables, 2 priority, 3 auto-clear, 4 global enable |
| wr_data | input | 22 | Write data, one bit per source (bit 0 for the global enable) |
| insn_done | input | 1 | The current instruction has completed |
| vec_ack | input | 1 | The CPU takes the presented vector |
| reti | input | 1 | A service routine returns |
| irq_req | output | 1 | Vector request to the CPU |
| irq_idx | output | 5 | Index of the requesting source |
| irq_vec | output | 16 | Vector address of the requesting source |

## Verification
The assertions check on every cycle that a request rises only at an instruction boundary and holds steady until it is acknowledged. They also check that a cleared global enable or a high-level routine in service blocks new requests, that a hardware set survives a same-cycle software clear, and that auto-clear removes the acknowledged flag. The bench scenarios cover what depends on history and on which source wins. These are the priority and lowest-index choice across several flag patterns, the vector values, flags latched while disabled, the re-entry one instruction after a return, and the nested preemption order with its pops.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    SEL_PEND = 3'd0,
    SEL_EN   = 3'd1,
    SEL_PRIO = 3'd2,
    SEL_ACLR = 3'd3,
    SEL_GIE  = 3'd4
  } wr_sel_e;

  // Vector address for a source index: base plus index scaled by a power of two.
  function automatic logic [15:0] vec_of(input logic [7:0] idx,
                                         input logic [15:0] base,
                                         input int unsigned shl);
    return base + (16'(idx) << shl);
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_pkg::*;
#(
  parameter int NSRC = 22,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_set,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [NSRC-1:0] wr_data,
  input  logic            ack_evt,
  input  logic [IDXW-1:0] ack_idx,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] prio_q,
  output logic [NSRC-1:0] aclr_q,
  output logic            gie_q
);

  logic [NSRC-1:0] ack_clr;
  logic [NSRC-1:0] pend_sw;
  logic [NSRC-1:0] pend_d;

  // Per-source auto-clear decode on acknowledge.
  for (genvar g = 0; g < NSRC; g++) begin : g_clr
    assign ack_clr[g] = ack_evt && (ack_idx == IDXW'(g)) && aclr_q[g];
  end

  always_comb begin
    pend_sw = (wr_en && wr_sel == SEL_PEND) ? wr_data : pend_q;
    // Hardware set is applied last so it wins over any clear.
    pend_d  = (pend_sw & ~ack_clr) | src_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
      aclr_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (wr_en) begin
        case (wr_sel)
          SEL_EN:   en_q   <= wr_data;
          SEL_PRIO: prio_q <= wr_data;
          SEL_ACLR: aclr_q <= wr_data;
          SEL_GIE:  gie_q  <= wr_data[0];
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 22,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] cand,
  output logic            found,
  output logic [IDXW-1:0] idx
);

  always_comb begin
    found = |cand;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDXW'(i);
    end
  end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_hi,
  input  logic pop,
  output logic svc_lo,
  output logic svc_hi
);

  logic lo_after_pop;
  logic hi_after_pop;

  // A pop ends the most recent level, which is high whenever high is active.
  always_comb begin
    hi_after_pop = svc_hi && !pop;
    lo_after_pop = svc_lo && !(pop && !svc_hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_lo <= 1'b0;
      svc_hi <= 1'b0;
    end else begin
      svc_hi <= hi_after_pop || (push && push_hi);
      svc_lo <= lo_after_pop || (push && !push_hi);
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NSRC = 22,
  parameter int VEC_BASE = 3,
  parameter int VEC_SHIFT = 3,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_set,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [NSRC-1:0] wr_data,
  input  logic            insn_done,
  input  logic            vec_ack,
  input  logic            reti,
  output logic            irq_req,
  output logic [IDXW-1:0] irq_idx,
  output logic [15:0]     irq_vec
);

  logic [NSRC-1:0] pend_q, en_q, prio_q, aclr_q;
  logic            gie_q;
  logic [NSRC-1:0] cand, cand_hi, cand_lo;
  logic            hi_found, lo_found;
  logic [IDXW-1:0] hi_idx, lo_idx;
  logic            svc_lo, svc_hi;
  logic            win_ok, win_hi;
  logic [IDXW-1:0] win_idx;
  logic            take_evt, ack_evt;
  logic            req_q, lvl_q;
  logic [IDXW-1:0] idx_q;

  irq_pend_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_set(src_set),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ack_evt(ack_evt), .ack_idx(idx_q),
    .pend_q(pend_q), .en_q(en_q), .prio_q(prio_q), .aclr_q(aclr_q), .gie_q(gie_q)
  );

  always_comb begin
    cand    = pend_q & en_q & {NSRC{gie_q}};
    cand_hi = cand & prio_q;
    cand_lo = cand & ~prio_q;
  end

  irq_pick #(.NSRC(NSRC)) u_pick_hi (.cand(cand_hi), .found(hi_found), .idx(hi_idx));
  irq_pick #(.NSRC(NSRC)) u_pick_lo (.cand(cand_lo), .found(lo_found), .idx(lo_idx));

  irq_svc_track u_svc (
    .clk(clk), .rst_n(rst_n),
    .push(ack_evt), .push_hi(lvl_q), .pop(reti),
    .svc_lo(svc_lo), .svc_hi(svc_hi)
  );

  // Level gating: high-in-service blocks all, low-in-service blocks low.
  always_comb begin
    win_ok  = 1'b0;
    win_hi  = 1'b0;
    win_idx = '0;
    if (!svc_hi && hi_found) begin
      win_ok  = 1'b1;
      win_hi  = 1'b1;
      win_idx = hi_idx;
    end else if (!svc_hi && !svc_lo && lo_found) begin
      win_ok  = 1'b1;
      win_idx = lo_idx;
    end
  end

  assign take_evt = insn_done && !req_q && win_ok;
  assign ack_evt  = vec_ack && req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= 1'b0;
      idx_q <= '0;
    end else if (take_evt) begin
      req_q <= 1'b1;
      lvl_q <= win_hi;
      idx_q <= win_idx;
    end else if (ack_evt) begin
      req_q <= 1'b0;
    end
  end

  assign irq_req = req_q;
  assign irq_idx = idx_q;
  assign irq_vec = vec_of(8'(idx_q), 16'(VEC_BASE), VEC_SHIFT);

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NSRC = 22,
  localparam int IDXW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_set,
  input logic            wr_en,
  input logic [2:0]      wr_sel,
  input logic            insn_done,
  input logic            vec_ack,
  input logic            irq_req,
  input logic [IDXW-1:0] irq_idx,
  input logic [15:0]     irq_vec,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] aclr_q,
  input logic            gie_q,
  input logic            svc_hi
);

  p_rise_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(insn_done));

  p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !vec_ack) |=> (irq_req && $stable(irq_idx) && $stable(irq_vec)));

  p_drop_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && vec_ack) |=> !irq_req);

  p_gie_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q && !irq_req) |=> !irq_req);

  p_hi_no_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_hi && !irq_req) |=> !irq_req);

  p_hwset_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((pend_q & $past(src_set)) == $past(src_set)));

  p_autoclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && vec_ack && aclr_q[irq_idx] && !src_set[irq_idx]
     && !(wr_en && wr_sel == 3'd0)) |=> !pend_q[$past(irq_idx)]);

endmodule

bind irq_arbiter irq_arbiter_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_set(src_set), .wr_en(wr_en), .wr_sel(wr_sel),
  .insn_done(insn_done), .vec_ack(vec_ack), .irq_req(irq_req), .irq_idx(irq_idx),
  .irq_vec(irq_vec), .pend_q(pend_q), .aclr_q(aclr_q), .gie_q(gie_q), .svc_hi(svc_hi)
);

// File: tb/test_irq_arbiter.sv
`timescale 1ns/1ps
module test_irq_arbiter;

  localparam int N = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_set = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [N-1:0]  wr_data = '0;
  logic          insn_done = 1'b0;
  logic          vec_ack = 1'b0;
  logic          reti = 1'b0;
  logic          irq_req;
  logic [4:0]    irq_idx;
  logic [15:0]   irq_vec;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .insn_done(insn_done), .vec_ack(vec_ack), .reti(reti),
    .irq_req(irq_req), .irq_idx(irq_idx), .irq_vec(irq_vec)
  );

  typedef struct packed {
    logic [N-1:0] en;
    logic [N-1:0] pr;
    logic [N-1:0] pd;
    logic         req;
    logic [4:0]   idx;
  } vec_t;

  localparam vec_t TBL [0:6] = '{
    '{22'h3FFFFF, 22'h000000, 22'h000220, 1'b1, 5'd5},
    '{22'h3FFFFF, 22'h000200, 22'h000220, 1'b1, 5'd9},
    '{22'h3FFFDF, 22'h000000, 22'h000220, 1'b1, 5'd9},
    '{22'h000000, 22'h000000, 22'h000008, 1'b0, 5'd0},
    '{22'h3FFFFF, 22'h000000, 22'h200000, 1'b1, 5'd21},
    '{22'h3FFFFF, 22'h000000, 22'h000001, 1'b1, 5'd0},
    '{22'h3FFFFF, 22'h000084, 22'h000086, 1'b1, 5'd2}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_vec(input int idx);
    return 32'(3 + idx * 8);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk); insn_done = 1'b1;
    @(negedge clk); insn_done = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); vec_ack = 1'b1;
    @(negedge clk); vec_ack = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 50000);
      summary();
    end
  end

  initial begin
    // R11: reset state
    do_reset();
    chk("R11 req after reset", 32'(irq_req), 0);
    chk("R11 idx after reset", 32'(irq_idx), 0);
    step();
    chk("R11 no request from cleared state", 32'(irq_req), 0);

    // Table of priority patterns (R4, R5, R2, R8, R3)
    for (int t = 0; t < 7; t++) begin
      do_reset();
      wr(3'd4, 22'h1);
      wr(3'd1, TBL[t].en);
      wr(3'd2, TBL[t].pr);
      wr(3'd0, TBL[t].pd);
      chk($sformatf("R3 no request before boundary t%0d", t), 32'(irq_req), 0);
      step();
      chk($sformatf("R4 R8 req t%0d", t), 32'(irq_req), 32'(TBL[t].req));
      if (TBL[t].req) begin
        chk($sformatf("R4 idx t%0d", t), 32'(irq_idx), 32'(TBL[t].idx));
        chk($sformatf("R5 vec t%0d", t), 32'(irq_vec), exp_vec(int'(TBL[t].idx)));
      end
    end

    // R1: flag latched while disabled
    do_reset();
    wr(3'd4, 22'h1);
    @(negedge clk); src_set = 22'h000100;
    @(negedge clk); src_set = '0;
    step();
    chk("R1 disabled flag no request", 32'(irq_req), 0);
    wr(3'd1, 22'h000100);
    step();
    chk("R1 held flag requests after enable", 32'(irq_req), 1);
    chk("R1 idx", 32'(irq_idx), 8);

    // R2 global enable, R8 software set, R3 hold and drop
    do_reset();
    wr(3'd1, 22'h3FFFFF);
    wr(3'd0, 22'h000010);
    step();
    chk("R2 global enable off blocks", 32'(irq_req), 0);
    wr(3'd4, 22'h1);
    step();
    chk("R2 R8 request with global enable", 32'(irq_req), 1);
    chk("R8 idx", 32'(irq_idx), 4);
    wr(3'd0, 22'h000001);
    step();
    repeat (3) @(negedge clk);
    chk("R3 request held until ack", 32'(irq_req), 1);
    chk("R3 idx stable until ack", 32'(irq_idx), 4);
    ack();
    chk("R3 request drops after ack", 32'(irq_req), 0);

    // R6 / R7 / R9 low level
    do_reset();
    wr(3'd4, 22'h1);
    wr(3'd1, 22'h3FFFFF);
    wr(3'd3, 22'h000010);
    wr(3'd0, 22'h000040);
    step();
    chk("R7 first entry idx", 32'(irq_idx), 6);
    ack();
    step();
    chk("R9 low in service blocks low", 32'(irq_req), 0);
    @(negedge clk); reti = 1'b1; insn_done = 1'b1;
    @(negedge clk); reti = 1'b0; insn_done = 1'b0;
    chk("R7 no request in return cycle", 32'(irq_req), 0);
    step();
    chk("R7 re-entry after one instruction", 32'(irq_req), 1);
    chk("R6 flag kept without auto-clear", 32'(irq_idx), 6);
    ack();
    wr(3'd0, 22'h000000);
    ret();
    step();
    chk("R6 software clear removes flag", 32'(irq_req), 0);
    wr(3'd0, 22'h000010);
    step();
    chk("R6 auto-clear source idx", 32'(irq_idx), 4);
    ack();
    ret();
    step();
    chk("R6 auto-clear on ack", 32'(irq_req), 0);

    // R9 nesting
    do_reset();
    wr(3'd4, 22'h1);
    wr(3'd1, 22'h3FFFFF);
    wr(3'd3, 22'h000C00);
    wr(3'd2, 22'h000C00);
    wr(3'd0, 22'h000040);
    step();
    ack();
    wr(3'd0, 22'h000440);
    step();
    chk("R9 high preempts low", 32'(irq_req), 1);
    chk("R9 preempting idx", 32'(irq_idx), 10);
    ack();
    wr(3'd0, 22'h000840);
    step();
    chk("R9 high in service blocks high", 32'(irq_req), 0);
    ret();
    step();
    chk("R9 pop high allows high", 32'(irq_req), 1);
    chk("R9 second high idx", 32'(irq_idx), 11);
    ack();
    ret();
    step();
    chk("R9 low still in service", 32'(irq_req), 0);
    ret();
    step();
    chk("R9 all popped low re-enters", 32'(irq_req), 1);
    chk("R9 low idx", 32'(irq_idx), 6);

    // R10 set beats clear
    do_reset();
    wr(3'd4, 22'h1);
    wr(3'd1, 22'h3FFFFF);
    @(negedge clk); src_set = 22'h001000; wr_en = 1'b1; wr_sel = 3'd0; wr_data = '0;
    @(negedge clk); src_set = '0; wr_en = 1'b0;
    step();
    chk("R10 hardware set wins", 32'(irq_req), 1);
    chk("R10 idx", 32'(irq_idx), 12);

    summary();
  end

endmodule